// File: doc/BRIEF.md
# Configurable Carry-Lookahead ALU

This block is a combinational arithmetic and logic unit for a 16-bit datapath. Every bit position has a small configurable cell that computes two terms from the operand bits: a propagate term chosen by one 4-bit truth-table select and a generate term chosen by a second 4-bit truth-table select. A two-level carry-lookahead network turns these terms into the carry into every bit. Each result bit is then the XOR of its propagate term with its carry. A third select, the carry enable, either lets the carries through for arithmetic or forces them to zero. With the carries forced to zero the result is the propagate function itself, so the same cells carry out bitwise logic.

The truth-table selects are indexed by `{a_bit, b_bit}`, so a value of 4'b0110 chooses XOR, 4'b1000 chooses AND and 4'b1001 chooses XNOR. Subtraction is addition with the second operand inverted. That inversion is folded into the tables (propagate XNOR, generate `a & ~b`) together with a carry-in of 1. A shift left is an addition of an operand to itself. The carry-out comes straight from the second lookahead level, so the carry and overflow flags are ready before the sum bits. A parameter can select a plain ripple chain in place of the lookahead network when area matters more than depth.

Top module: `cla_alu`

## Requirements
- R1: With `carry_en`=0, each result bit i equals `prop_sel[{op_a[i],op_b[i]}]`, whatever the values of `carry_in` and `gen_sel`.
- R2: With `carry_en`=0, `flag_c` and `flag_v` are 0.
- R3: With `prop_sel`=4'b0110, `gen_sel`=4'b1000 and `carry_en`=1, `{flag_c,result}` equals `op_a + op_b + carry_in`.
- R4: With `prop_sel`=4'b1001, `gen_sel`=4'b0100, `carry_en`=1 and `carry_in`=1, `result` equals `op_a - op_b` modulo 2^16, and `flag_c` is 1 exactly when `op_a >= op_b` taken as unsigned values.
- R5: With `carry_en`=1, `flag_v` is the XOR of the carry into bit 15 and the carry out of bit 15. In the add setting this is 1 exactly on signed overflow.
- R6: `flag_z` is 1 exactly when all 16 result bits are 0.
- R7: A carry made at bit 0 passes through every 4-bit group when all higher bits propagate. For example, 16'hFFFF + 1 gives a result of 0 with `flag_c`=1.
- R8: Adding an operand to itself in the add setting gives `{op_a[14:0], carry_in}` as the result, and `flag_c` equals `op_a[15]`.
- R9: With `carry_en`=1 and any selects, the carry into bit i+1 is `g_i | (p_i & c_i)`, where the carry into bit 0 is `carry_in`.
- R10: The ripple variant (`LOOKAHEAD`=0) gives the same outputs as the lookahead variant for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0, used only when carry_en is 1 |
| prop_sel | input | 4 | Truth table of the per-bit propagate function, indexed by {a,b} |
| gen_sel | input | 4 | Truth table of the per-bit generate function, indexed by {a,b} |
| carry_en | input | 1 | 1 lets the carries through (arithmetic), 0 forces them to zero (logic) |
| result | output | 16 | Result word |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry out of the top bit |
| flag_v | output | 1 | Carry into the top bit XOR carry out of it |

## Verification
The hardest case to reach from the ports is a carry that starts in the lowest group and has to cross all three higher groups through the second-level unit. This needs every higher bit to propagate without generating, which random operands almost never give. Directed vectors therefore build full-propagate patterns such as 16'hFFFF plus 1 and 16'h7FFF plus 1. Random truth-table selects then drive combinations of propagate and generate that the add and subtract settings never produce. Every output is compared against a bit-serial model and against a second instance built with the ripple variant.

// File: rtl/cla_alu_pkg.sv
`timescale 1ns/1ps
package cla_alu_pkg;

   // Truth tables are indexed by {a_bit, b_bit}
   localparam logic [3:0] TT_AND      = 4'b1000;
   localparam logic [3:0] TT_OR       = 4'b1110;
   localparam logic [3:0] TT_XOR      = 4'b0110;
   localparam logic [3:0] TT_XNOR     = 4'b1001;
   localparam logic [3:0] TT_A_ANDN_B = 4'b0100;

   function automatic logic tt_eval(input logic [3:0] table_bits,
                                    input logic a_bit,
                                    input logic b_bit);
      return table_bits[{a_bit, b_bit}];
   endfunction

endpackage

// File: rtl/cla_bit_cell.sv
`timescale 1ns/1ps
module cla_bit_cell
   import cla_alu_pkg::*;
(
   input  logic       a_bit,
   input  logic       b_bit,
   input  logic [3:0] prop_sel,
   input  logic [3:0] gen_sel,
   output logic       p_out,
   output logic       g_out
);

   always_comb begin
      p_out = tt_eval(prop_sel, a_bit, b_bit);
      g_out = tt_eval(gen_sel,  a_bit, b_bit);
   end

endmodule

// File: rtl/cla_unit.sv
`timescale 1ns/1ps
module cla_unit #(
   parameter int N = 4
) (
   input  logic [N-1:0] p_in,
   input  logic [N-1:0] g_in,
   input  logic         c_in,
   output logic [N-1:0] c_bit,
   output logic         grp_p,
   output logic         grp_g,
   output logic         c_out
);

   generate
      if (N < 2) begin : g_bad_n
         $error("cla_unit: N must be at least 2");
      end
   endgenerate

   // Carry into position idx, as a flat sum of products
   function automatic logic la_carry(input logic [N-1:0] p,
                                     input logic [N-1:0] g,
                                     input logic         cin,
                                     input int           idx);
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = N - 1; j >= 0; j--) begin
         if (j < idx) begin
            acc = acc | (g[j] & run);
            run = run & p[j];
         end
      end
      return acc | (run & cin);
   endfunction

   always_comb begin
      for (int i = 0; i < N; i++) begin
         c_bit[i] = la_carry(p_in, g_in, c_in, i);
      end
      grp_p = &p_in;
      grp_g = la_carry(p_in, g_in, 1'b0, N);
      c_out = grp_g | (grp_p & c_in);
   end

   // Group carry-out agrees with one ripple step from the top bit's carry
   always_comb begin
      AST_GROUP_STEP: assert (c_out == (g_in[N-1] | (p_in[N-1] & c_bit[N-1])));  // R9
   end

endmodule

// File: rtl/cla_alu.sv
`timescale 1ns/1ps
module cla_alu
   import cla_alu_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter int GROUP     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   input  logic [3:0]       prop_sel,
   input  logic [3:0]       gen_sel,
   input  logic             carry_en,
   output logic [WIDTH-1:0] result,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);

   localparam int NGRP = WIDTH / GROUP;
   localparam int MSB  = WIDTH - 1;

   generate
      if (WIDTH % GROUP != 0) begin : g_bad_div
         $error("cla_alu: WIDTH must be a multiple of GROUP");
      end
      if (NGRP < 2 || NGRP > GROUP) begin : g_bad_levels
         $error("cla_alu: two lookahead levels need 2 <= WIDTH/GROUP <= GROUP");
      end
   endgenerate

   logic [WIDTH-1:0] p_vec;
   logic [WIDTH-1:0] g_vec;
   logic [WIDTH-1:0] carry_vec;
   logic             cout_raw;
   logic             cin_eff;

   assign cin_eff = carry_en & carry_in;

   // Per-bit configurable cells
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         cla_bit_cell u_cell (
            .a_bit    (op_a[i]),
            .b_bit    (op_b[i]),
            .prop_sel (prop_sel),
            .gen_sel  (gen_sel),
            .p_out    (p_vec[i]),
            .g_out    (g_vec[i])
         );
      end
   endgenerate

   // Carry network variant
   generate
      if (LOOKAHEAD) begin : g_la
         logic [NGRP-1:0] grp_p;
         logic [NGRP-1:0] grp_g;
         logic [NGRP-1:0] grp_cin;
         logic [NGRP-1:0] cout_l1;
         logic            top_p;
         logic            top_g;

         for (genvar k = 0; k < NGRP; k++) begin : g_l1
            cla_unit #(.N(GROUP)) u_l1 (
               .p_in  (p_vec[k*GROUP +: GROUP]),
               .g_in  (g_vec[k*GROUP +: GROUP]),
               .c_in  (grp_cin[k]),
               .c_bit (carry_vec[k*GROUP +: GROUP]),
               .grp_p (grp_p[k]),
               .grp_g (grp_g[k]),
               .c_out (cout_l1[k])
            );
         end

         cla_unit #(.N(NGRP)) u_l2 (
            .p_in  (grp_p),
            .g_in  (grp_g),
            .c_in  (cin_eff),
            .c_bit (grp_cin),
            .grp_p (top_p),
            .grp_g (top_g),
            .c_out (cout_raw)
         );

         // Second level carries match the first level group outputs
         always_comb begin
            for (int k = 0; k < NGRP - 1; k++) begin
               AST_CARRY_AGREE: assert (cout_l1[k] == grp_cin[k+1]);  // R7
            end
            AST_CARRY_TOP: assert (cout_l1[NGRP-1] == cout_raw);  // R7
            if (top_g) begin
               AST_TOP_GEN: assert (cout_raw);  // R9
            end
            if (top_p && !top_g) begin
               AST_TOP_PROP: assert (cout_raw == cin_eff);  // R9
            end
         end
      end else begin : g_rip
         logic [WIDTH:0] rc;
         assign rc[0] = cin_eff;
         for (genvar i = 0; i < WIDTH; i++) begin : g_step
            assign rc[i+1] = g_vec[i] | (p_vec[i] & rc[i]);
         end
         assign carry_vec = rc[WIDTH-1:0];
         assign cout_raw  = rc[WIDTH];
      end
   endgenerate

   // Result and flags
   always_comb begin
      result = p_vec ^ (carry_vec & {WIDTH{carry_en}});
      flag_z = ~|result;
      flag_c = carry_en & cout_raw;
      flag_v = carry_en & (carry_vec[MSB] ^ cout_raw);
   end

   // Independent reference sum for the add setting
   logic [WIDTH:0] ref_sum;
   logic           add_mode;
   always_comb begin
      ref_sum  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
      add_mode = carry_en && (prop_sel == TT_XOR) && (gen_sel == TT_AND);
   end

   always_comb begin
      if (add_mode) begin
         AST_ADD_SUM: assert ({flag_c, result} == ref_sum);  // R3
         AST_OVF_SIGN: assert (flag_v == ((op_a[MSB] == op_b[MSB]) && (ref_sum[MSB] != op_a[MSB])));  // R5
         AST_ZERO_SUM: assert (flag_z == (ref_sum[WIDTH-1:0] == '0));  // R6
      end
      if (!carry_en && prop_sel == TT_AND) begin
         AST_LOGIC_AND: assert (result == (op_a & op_b));  // R1
      end
      if (!carry_en && prop_sel == TT_XOR) begin
         AST_LOGIC_XOR: assert (result == (op_a ^ op_b));  // R1
      end
      if (!carry_en && prop_sel == TT_OR) begin
         AST_LOGIC_OR: assert (result == (op_a | op_b));  // R1
      end
   end

endmodule

// File: tb/cla_alu_test.sv
`timescale 1ns/1ps
module cla_alu_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         carry_in = 1'b0;
   logic [3:0]   prop_sel = 4'b0110;
   logic [3:0]   gen_sel  = 4'b1000;
   logic         carry_en = 1'b1;

   logic [W-1:0] result, result_r;
   logic         flag_z, flag_c, flag_v;
   logic         flag_z_r, flag_c_r, flag_v_r;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   cla_alu #(.WIDTH(W), .GROUP(4), .LOOKAHEAD(1'b1)) uut (
      .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .prop_sel(prop_sel), .gen_sel(gen_sel), .carry_en(carry_en),
      .result(result), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   cla_alu #(.WIDTH(W), .GROUP(4), .LOOKAHEAD(1'b0)) uut_rip (
      .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .prop_sel(prop_sel), .gen_sel(gen_sel), .carry_en(carry_en),
      .result(result_r), .flag_z(flag_z_r), .flag_c(flag_c_r), .flag_v(flag_v_r)
   );

   // Bit-serial model: returns {v, c, z, result}
   function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic cin, input logic [3:0] ps,
                                          input logic [3:0] gs, input logic ce);
      logic [W-1:0] res;
      logic carry, c_msb, p, g;
      carry = ce & cin;
      c_msb = 1'b0;
      for (int i = 0; i < W; i++) begin
         p = ps[{a[i], b[i]}];
         g = gs[{a[i], b[i]}];
         if (i == W - 1) c_msb = carry;
         res[i] = p ^ (ce & carry);
         carry  = g | (p & carry);
      end
      return {ce & (c_msb ^ carry), ce & carry, (res == '0), res};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic cin,
                        input logic [3:0] ps, input logic [3:0] gs, input logic ce);
      @(negedge clk);
      op_a = a; op_b = b; carry_in = cin;
      prop_sel = ps; gen_sel = gs; carry_en = ce;
      #1;
   endtask

   function automatic logic [31:0] outs();
      return {13'd0, flag_v, flag_c, flag_z, result};
   endfunction

   initial begin
      logic [W-1:0] a, b;
      logic [W+2:0] exp;
      int seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // Reset-state inputs: 0 + 0
      apply(16'h0000, 16'h0000, 1'b0, 4'b0110, 4'b1000, 1'b1);
      chk("R6 zero sum", outs(), {13'd0, 3'b001, 16'h0000});

      // R7: carry crosses all groups
      apply(16'hFFFF, 16'h0001, 1'b0, 4'b0110, 4'b1000, 1'b1);
      chk("R7 full propagate", outs(), {13'd0, 3'b011, 16'h0000});
      apply(16'hFFFF, 16'h0000, 1'b1, 4'b0110, 4'b1000, 1'b1);
      chk("R7 carry_in propagate", outs(), {13'd0, 3'b011, 16'h0000});

      // R5: signed overflow
      apply(16'h7FFF, 16'h0001, 1'b0, 4'b0110, 4'b1000, 1'b1);
      chk("R5 positive overflow", outs(), {13'd0, 3'b100, 16'h8000});
      apply(16'h8000, 16'h8000, 1'b0, 4'b0110, 4'b1000, 1'b1);
      chk("R5 negative overflow", outs(), {13'd0, 3'b111, 16'h0000});

      // R4: subtraction
      apply(16'd5, 16'd5, 1'b1, 4'b1001, 4'b0100, 1'b1);
      chk("R4 equal sub", outs(), {13'd0, 3'b011, 16'h0000});
      apply(16'd3, 16'd5, 1'b1, 4'b1001, 4'b0100, 1'b1);
      chk("R4 borrow sub", outs(), {13'd0, 3'b000, 16'hFFFE});
      apply(16'h8000, 16'h0001, 1'b1, 4'b1001, 4'b0100, 1'b1);
      chk("R4 R5 sub overflow", outs(), {13'd0, 3'b110, 16'h7FFF});

      // R8: shift left by self-add
      apply(16'hC001, 16'hC001, 1'b1, 4'b0110, 4'b1000, 1'b1);
      chk("R8 shift left", outs(), {13'd0, 3'b010, 16'h8003});

      // R1 R2: logic mode ignores carry_in and gen_sel
      apply(16'hF0F0, 16'hFF00, 1'b1, 4'b1000, 4'b1111, 1'b0);
      chk("R1 R2 AND", outs(), {13'd0, 3'b000, 16'hF000});
      apply(16'hF0F0, 16'hFF00, 1'b1, 4'b1110, 4'b1111, 1'b0);
      chk("R1 R2 OR", outs(), {13'd0, 3'b000, 16'hFFF0});
      apply(16'hF0F0, 16'hF0F0, 1'b1, 4'b0110, 4'b1000, 1'b0);
      chk("R1 R2 R6 XOR zero", outs(), {13'd0, 3'b001, 16'h0000});

      // Random mixes
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] ps, gs;
         logic ce, cin;
         a   = 16'($urandom);
         b   = 16'($urandom);
         cin = 1'($urandom);
         ps  = 4'($urandom);
         gs  = 4'($urandom);
         ce  = 1'($urandom);
         if (n % 3 == 0) begin ps = 4'b0110; gs = 4'b1000; ce = 1'b1; end
         apply(a, b, cin, ps, gs, ce);
         exp = model(a, b, cin, ps, gs, ce);
         chk("R9 model", outs(), {13'd0, exp});
         chk("R10 ripple match", {13'd0, flag_v_r, flag_c_r, flag_z_r, result_r}, outs());
         if (n % 3 == 0)
            chk("R3 add sum", {15'd0, flag_c, result}, 32'({1'b0, a} + {1'b0, b} + 17'(cin)));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule